// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Ring Controller

This block owns a ring of four transmit descriptors that software fills through a small word-wide register port. Each slot holds three words: a completion status word, a frame length word and an address word. The address word carries the 2 KiB-aligned buffer base in its upper bits and two handover flags in its low bits. Software sets the enable flag to hand a slot to the hardware. The hardware sets the done flag when it is finished with that slot. Slot 0's address word also shows which slot the hardware will serve next, so a driver can line up its own pointer after reset.

When transmission is switched on, the sequencer works through the slots strictly in ring order. For each enabled slot it reads the frame bytes from a one-cycle-latency memory read port and presents them one per cycle on a byte-wide transmit output. Frames shorter than 60 bytes are padded with zero bytes up to 60. Collision pulses from the line side are counted during a frame, and the sixteenth collision ends the frame early as aborted. At the end of each frame the sequencer writes a status word into the slot, clears the enable flag, sets the done flag and moves to the next slot. A level interrupt stays high while any slot holds an unacknowledged done flag.

The sequencer has three named states. In IDLE it waits at the current slot. It leaves through the transition START when the transmit-enable bit and the slot's enable flag are both set, and it latches base and length as it does so. In SEND it issues one memory read or pad byte per cycle. It leaves through the transition END when the last byte is issued, or through ABORT on the sixteenth collision. In FINISH it writes back the slot for one cycle and takes the transition NEXT back to IDLE, with the slot index advanced by one modulo four.

Top module: `txr_ring`

## Requirements
- R1: After reset every register reads zero, `irq` and `tx_valid` are low and the next-slot index is 0.
- R2: Register address is {slot[1:0], field[1:0]}. Field 0 is status, field 1 is length (bits 10:0), field 2 is the address word and field 3 is control, where bit 0 is transmit enable. The address word holds the base in bits 31:11, done in bit 1 and enable in bit 0. In slot 0's address word only, bits 3:2 hold the next-slot index.
- R3: Slots are served strictly in ring order. After each frame the index advances to (index+1) mod 4. The sequencer waits at a slot whose enable flag is clear and never skips ahead.
- R4: Frame bytes are read from memory address {base[15:11], byte index[10:0]} in rising order and appear on `tx_data` with `tx_valid` high, one byte per cycle.
- R5: A frame with length below 60 is sent as exactly 60 bytes: the stored bytes first, then zeros. A frame of 60 or more is sent at its programmed length.
- R6: On completion the slot's done flag is set, its enable flag is cleared and its status word is written.
- R7: Any software write to a slot's address word clears that slot's done flag.
- R8: `irq` is high exactly while at least one slot has its done flag set.
- R9: Status bits 7:4 give the number of collision pulses seen during the frame. Bits 1:0 are zero when fewer than 16 collisions occurred.
- R10: The sixteenth collision in a frame ends it early. Status then has bit 0 (aborted) and bit 1 (excessive collisions) set, and bits 7:4 read 15.
- R11: Transmit enable gates frame start only. Clearing it during a frame lets that frame finish but starts no further frame until it is set again.
- R12: Base and length are latched at frame start. Writes to the slot's length during its frame do not change the frame in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {slot, field} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Memory data, valid the cycle after mem_rd |
| line_col | input | 1 | Collision pulse from the line side |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt, any done flag pending |

## Verification
The hardest situations to reach from the ports are the ones that must land inside a frame that is already running: the sixteen-collision abort, a mid-frame clear of transmit enable, and a length rewrite on the slot being sent. The bench waits for the first `tx_valid` of a long frame and then drives collision pulses or register writes on the following falling edges. This places them inside SEND with many bytes still outstanding. Ring-order stalls are reached by enabling the slot after the current one first and holding there before enabling the current slot.

// File: rtl/txr_pkg.sv
package txr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_FINISH = 2'd2
    } txr_state_e;

    localparam logic [1:0] FLD_STAT = 2'd0;
    localparam logic [1:0] FLD_LEN  = 2'd1;
    localparam logic [1:0] FLD_ADDR = 2'd2;
    localparam logic [1:0] FLD_CTRL = 2'd3;

    localparam int COL_LIMIT = 16;
endpackage

// File: rtl/txr_regs.sv
module txr_regs import txr_pkg::*; #(
    parameter int NSLOT  = 4,
    parameter int LEN_W  = 11,
    parameter int MEM_AW = 16,
    parameter int SLOT_W = $clog2(NSLOT),
    parameter int MB_W   = MEM_AW - LEN_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [SLOT_W+1:0]             addr,
    input  logic [31:0]                   wdata,
    output logic [31:0]                   rdata,
    input  logic                          wb_valid,
    input  logic [SLOT_W-1:0]             wb_slot,
    input  logic [7:0]                    wb_stat,
    input  logic [SLOT_W-1:0]             cur_slot,
    output logic [NSLOT-1:0]              slot_en,
    output logic [NSLOT-1:0][LEN_W-1:0]   slot_len,
    output logic [NSLOT-1:0][MB_W-1:0]    slot_base,
    output logic                          txen,
    output logic                          irq
);
    localparam int BASE_W = 32 - LEN_W;

    logic [SLOT_W-1:0] sel;
    logic [1:0]        fld;
    logic [NSLOT-1:0]  done_v;
    logic [NSLOT-1:0][BASE_W-1:0] base_v;
    logic [NSLOT-1:0][7:0]        stat_v;

    assign sel = addr[SLOT_W+1:2];
    assign fld = addr[1:0];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic hit;
        logic hw_wb;
        assign hit   = wr && (sel == SLOT_W'(g));
        assign hw_wb = wb_valid && (wb_slot == SLOT_W'(g));

        // hardware completion has priority over software on flags and status
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_en[g] <= 1'b0;
                done_v[g]  <= 1'b0;
                stat_v[g]  <= '0;
            end else if (hw_wb) begin
                slot_en[g] <= 1'b0;
                done_v[g]  <= 1'b1;
                stat_v[g]  <= wb_stat;
            end else if (hit && fld == FLD_ADDR) begin
                slot_en[g] <= wdata[0];
                done_v[g]  <= 1'b0;
            end else if (hit && fld == FLD_STAT) begin
                stat_v[g]  <= wdata[7:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_len[g] <= '0;
                base_v[g]   <= '0;
            end else begin
                if (hit && fld == FLD_LEN)  slot_len[g] <= wdata[LEN_W-1:0];
                if (hit && fld == FLD_ADDR) base_v[g]   <= wdata[31:LEN_W];
            end
        end

        assign slot_base[g] = base_v[g][MB_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      txen <= 1'b0;
        else if (wr && fld == FLD_CTRL)  txen <= wdata[0];
    end

    assign irq = |done_v;

    always_comb begin
        rdata = '0;
        unique case (fld)
            FLD_STAT: rdata[7:0]       = stat_v[sel];
            FLD_LEN:  rdata[LEN_W-1:0] = slot_len[sel];
            FLD_ADDR: begin
                rdata[31:LEN_W] = base_v[sel];
                rdata[1]        = done_v[sel];
                rdata[0]        = slot_en[sel];
                if (sel == '0) rdata[2 +: SLOT_W] = cur_slot;
            end
            FLD_CTRL: rdata[0] = txen;
        endcase
    end
endmodule

// File: rtl/txr_seq.sv
module txr_seq import txr_pkg::*; #(
    parameter int NSLOT   = 4,
    parameter int LEN_W   = 11,
    parameter int MEM_AW  = 16,
    parameter int MIN_LEN = 60,
    parameter int SLOT_W  = $clog2(NSLOT),
    parameter int MB_W    = MEM_AW - LEN_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         txen,
    input  logic [NSLOT-1:0]             slot_en,
    input  logic [NSLOT-1:0][LEN_W-1:0]  slot_len,
    input  logic [NSLOT-1:0][MB_W-1:0]   slot_base,
    input  logic                         line_col,
    input  logic [7:0]                   mem_rdata,
    output logic                         mem_rd,
    output logic [MEM_AW-1:0]            mem_addr,
    output logic                         tx_valid,
    output logic [7:0]                   tx_data,
    output logic                         wb_valid,
    output logic [SLOT_W-1:0]            wb_slot,
    output logic [7:0]                   wb_stat,
    output logic [SLOT_W-1:0]            cur_slot,
    output logic                         busy
);
    localparam int COL_W = $clog2(COL_LIMIT) + 1;

    txr_state_e        state_q, state_d;
    logic [SLOT_W-1:0] cur_q;
    logic [MB_W-1:0]   base_q;
    logic [LEN_W-1:0]  raw_q, eff_q, idx_q;
    logic [COL_W-1:0]  col_q;
    logic              pipe_q, real_q;
    logic              go, abort_now, last, issue;

    assign go        = (state_q == ST_IDLE) && txen && slot_en[cur_q];
    assign abort_now = (state_q == ST_SEND) && line_col && (col_q == COL_W'(COL_LIMIT - 1));
    assign last      = (idx_q == eff_q - 1'b1);
    assign issue     = (state_q == ST_SEND) && !abort_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_SEND;                       // START
            ST_SEND:   if (abort_now || last) state_d = ST_FINISH;      // ABORT / END
            ST_FINISH: state_d = ST_IDLE;                               // NEXT
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            base_q <= '0;
            raw_q  <= '0;
            eff_q  <= '0;
            idx_q  <= '0;
            col_q  <= '0;
            pipe_q <= 1'b0;
            real_q <= 1'b0;
        end else begin
            pipe_q <= issue;
            real_q <= issue && (idx_q < raw_q);
            unique case (state_q)
                ST_IDLE: if (go) begin
                    base_q <= slot_base[cur_q];
                    raw_q  <= slot_len[cur_q];
                    eff_q  <= (slot_len[cur_q] < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : slot_len[cur_q];
                    idx_q  <= '0;
                    col_q  <= '0;
                end
                ST_SEND: begin
                    idx_q <= idx_q + 1'b1;
                    if (line_col) col_q <= col_q + 1'b1;
                end
                ST_FINISH: cur_q <= cur_q + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_rd   = issue && (idx_q < raw_q);
        mem_addr = {base_q, idx_q};
        tx_valid = pipe_q;
        tx_data  = real_q ? mem_rdata : 8'h00;
        wb_valid = (state_q == ST_FINISH);
        wb_slot  = cur_q;
        wb_stat  = {(col_q[COL_W-1] ? 4'hF : col_q[3:0]), 2'b00,
                    col_q[COL_W-1], col_q[COL_W-1]};
        cur_slot = cur_q;
        busy     = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/txr_ring.sv
module txr_ring #(
    parameter int NSLOT   = 4,
    parameter int LEN_W   = 11,
    parameter int MEM_AW  = 16,
    parameter int MIN_LEN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_rd,
    output logic [15:0]       mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              line_col,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int MB_W   = MEM_AW - LEN_W;

    logic [NSLOT-1:0]             slot_en;
    logic [NSLOT-1:0][LEN_W-1:0]  slot_len;
    logic [NSLOT-1:0][MB_W-1:0]   slot_base;
    logic                         txen, wb_valid, busy;
    logic [SLOT_W-1:0]            wb_slot, cur_slot;
    logic [7:0]                   wb_stat;

    txr_regs #(.NSLOT(NSLOT), .LEN_W(LEN_W), .MEM_AW(MEM_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .wb_valid(wb_valid), .wb_slot(wb_slot), .wb_stat(wb_stat),
        .cur_slot(cur_slot), .slot_en(slot_en), .slot_len(slot_len),
        .slot_base(slot_base), .txen(txen), .irq(irq)
    );

    txr_seq #(.NSLOT(NSLOT), .LEN_W(LEN_W), .MEM_AW(MEM_AW), .MIN_LEN(MIN_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .txen(txen), .slot_en(slot_en), .slot_len(slot_len),
        .slot_base(slot_base), .line_col(line_col), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .tx_valid(tx_valid), .tx_data(tx_data),
        .wb_valid(wb_valid), .wb_slot(wb_slot), .wb_stat(wb_stat),
        .cur_slot(cur_slot), .busy(busy)
    );
endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              tx_valid,
    input logic              mem_rd,
    input logic              wb_valid,
    input logic [SLOT_W-1:0] cur_slot,
    input logic              txen,
    input logic              busy
);
    p_read_emits_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> tx_valid);

    p_byte_only_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    p_ring_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_slot != $past(cur_slot)) |-> (cur_slot == SLOT_W'($past(cur_slot) + 1'b1)));

    p_done_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> irq);

    p_single_writeback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    p_no_start_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !txen) |=> !busy);
endmodule

bind txr_ring txr_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .tx_valid(tx_valid), .mem_rd(mem_rd),
    .wb_valid(wb_valid), .cur_slot(cur_slot), .txen(txen), .busy(busy)
);

// File: tb/sim_txr_ring.sv
module sim_txr_ring;
    localparam int PERIOD = 10;
    localparam int MINL   = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        line_col = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int ncap = 0;
    bit finished = 0;
    int exp_ptr = 0;
    logic [7:0] cap [0:511];

    txr_ring u0 (.*);

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[15:11], a[10:8]};
    endfunction

    // memory model: one cycle read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

    always @(negedge clk) if (tx_valid && ncap < 512) begin
        cap[ncap] = tx_data;
        ncap = ncap + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input int s, output bit ok);
        logic [31:0] d;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(s*4+2, d);
            if (d[1]) begin ok = 1; break; end
        end
    endtask

    task automatic wait_tx();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (tx_valid) break;
        end
    endtask

    function automatic int effl(input int l);
        return (l < MINL) ? MINL : l;
    endfunction

    // compare captured bytes [off..off+eff) against base/len
    function automatic int mism(input int off, input int b, input int l);
        int m = 0;
        for (int i = 0; i < effl(l); i++) begin
            logic [7:0] e;
            e = (i < l) ? pat({5'(b), 11'(i)}) : 8'h00;
            if (cap[off+i] !== e) m++;
        end
        return m;
    endfunction

    task automatic arm(input int s, input int b, input int l);
        wr(s*4+1, 32'(l));
        wr(s*4+2, (32'(b) << 11) | 32'h1);
    endtask

    task automatic frame(input int b, input int l);
        bit ok;
        logic [31:0] d;
        int s;
        s = exp_ptr;
        ncap = 0;
        arm(s, b, l);
        wait_done(s, ok);
        chk(ok, "R6 done set", int'(ok), 1);
        chk(ncap == effl(l), "R5 byte count", ncap, effl(l));
        chk(mism(0, b, l) == 0, "R4 data/pad", mism(0, b, l), 0);
        rd(s*4+0, d);
        chk(d == 0, "R9 clean status", d, 0);
        rd(s*4+2, d);
        chk(d[0] == 1'b0 && d[31:11] == 21'(b), "R6 enable cleared", d, b << 11);
        chk(irq == 1'b1, "R8 irq while done", irq, 1);
        wr(s*4+2, 0);
        rd(s*4+2, d);
        chk(d[1] == 1'b0, "R7 ack clears done", d[1], 0);
        chk(irq == 1'b0, "R8 irq after ack", irq, 0);
        exp_ptr = (exp_ptr + 1) % 4;
        rd(2, d);
        chk(int'(d[3:2]) == exp_ptr, "R3 next index", d[3:2], exp_ptr);
    endtask

    initial begin
        logic [31:0] d;
        bit ok;
        int lens [9] = '{0, 1, 2, 59, 60, 61, 64, 127, 200};
        int p, q;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(a, d);
            chk(d == 0, "R1 reset register", d, 0);
        end
        chk(irq == 0 && tx_valid == 0, "R1 reset outputs", {irq, tx_valid}, 0);

        // R11 transmit disabled: nothing starts
        arm(0, 9, 10);
        repeat (80) @(negedge clk);
        chk(ncap == 0, "R11 gated when disabled", ncap, 0);
        wr(3, 1);                          // R2 control field bit0
        rd(7, d);
        chk(d == 1, "R2 control readback", d, 1);
        wait_done(0, ok);
        chk(ok && ncap == 60 && mism(0, 9, 10) == 0, "R11 starts when enabled", ncap, 60);
        wr(2, 0);
        exp_ptr = 1;

        // R3/R4/R5 sweep of lengths across the wrapping ring
        foreach (lens[k]) frame((k*7+3) % 32, lens[k]);

        // R3 stall: enable next slot first, then the current one
        p = exp_ptr; q = (exp_ptr + 1) % 4;
        ncap = 0;
        arm(q, 21, 60);
        repeat (100) @(negedge clk);
        rd(q*4+2, d);
        chk(ncap == 0 && d[1] == 0, "R3 stall on clear slot", ncap, 0);
        arm(p, 17, 60);
        wait_done(q, ok);
        chk(ncap == 120, "R3 both sent", ncap, 120);
        chk(mism(0, 17, 60) == 0 && mism(60, 21, 60) == 0, "R3 ring order", cap[5], pat({5'd17, 11'd5}));
        // R8 level with two pending done flags
        wr(p*4+2, 0);
        chk(irq == 1, "R8 irq with one pending", irq, 1);
        wr(q*4+2, 0);
        chk(irq == 0, "R8 irq all acked", irq, 0);
        exp_ptr = (exp_ptr + 2) % 4;

        // R9 three collisions
        p = exp_ptr; ncap = 0;
        arm(p, 5, 200);
        wait_tx();
        repeat (3) begin line_col = 1; @(negedge clk); line_col = 0; @(negedge clk); end
        wait_done(p, ok);
        rd(p*4+0, d);
        chk(d == 32'h30, "R9 collision count", d, 32'h30);
        chk(ncap == 200, "R9 full frame", ncap, 200);
        wr(p*4+2, 0); exp_ptr = (exp_ptr + 1) % 4;

        // R10 sixteen collisions abort
        p = exp_ptr; ncap = 0;
        arm(p, 6, 200);
        wait_tx();
        line_col = 1; repeat (16) @(negedge clk); line_col = 0;
        wait_done(p, ok);
        rd(p*4+0, d);
        chk(d == 32'hF3, "R10 abort status", d, 32'hF3);
        chk(ncap > 0 && ncap < 200, "R10 truncated", ncap, 20);
        wr(p*4+2, 0); exp_ptr = (exp_ptr + 1) % 4;

        // R12 length rewrite during frame has no effect
        p = exp_ptr; ncap = 0;
        arm(p, 11, 100);
        wait_tx();
        wr(p*4+1, 10);
        wait_done(p, ok);
        chk(ncap == 100 && mism(0, 11, 100) == 0, "R12 latched length", ncap, 100);
        rd(p*4+1, d);
        chk(d == 10, "R12 length register updated", d, 10);
        wr(p*4+2, 0); exp_ptr = (exp_ptr + 1) % 4;

        // R11 clearing enable mid-frame
        p = exp_ptr; q = (exp_ptr + 1) % 4; ncap = 0;
        arm(q, 13, 60);
        arm(p, 12, 150);
        wait_tx();
        wr(3, 0);
        wait_done(p, ok);
        repeat (200) @(negedge clk);
        rd(q*4+2, d);
        chk(ok && ncap == 150 && d[1] == 0, "R11 current finishes, next held", ncap, 150);
        wr(3, 1);
        wait_done(q, ok);
        chk(ncap == 210 && mism(150, 13, 60) == 0, "R11 resumes", ncap, 210);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule